// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block runs external memory cycles for a small processor over one shared 16-bit address/data bus. A request carries an address, a read or write flag, a byte or word size, an instruction-fetch flag and write data. The controller drives the address-latch strobe, the read strobe, the write strobes, the active-low high-byte enable and the fetch flag. It returns read data and a one-cycle completion pulse.

All timing counts oscillator clocks. One internal state lasts three oscillator clocks, and a divided clock output marks the first clock of each state. A bus cycle has three parts. The address state comes first. One or more data states follow, and one extra state is added for each wait state that the ready input asks for, up to a configured limit. A closing state ends the cycle. The bus width is chosen for each request. A configuration input enables per-request selection, and the width pin is sampled when the request is accepted. A word request on an 8-bit cycle runs as two byte cycles, and the two bytes are returned together as one 16-bit value. Write strobes are either one common strobe or two strobes, one for each byte lane.

Top module: `xbus_ctrl`

## Requirements
- R1: When no external access is in progress, including after reset, the following hold. `rd_n_o`, `wr_n_o`, `wrh_n_o` and `bhe_n_o` are 1. `inst_o`, `ad_oe_o` and `busy_o` are 0. `ale_o` is 0 in latch mode and 1 in address-valid mode.
- R2: `clkout_o` is high for exactly one oscillator clock in every three.
- R3: The bus cycle begins with a 3-clock address state. During this state `ad_o` carries the cycle address and `ad_oe_o` is 1. In latch mode (`cfg_adv_i`=0), `ale_o` is high for exactly those 3 clocks. In address-valid mode (`cfg_adv_i`=1), `ale_o` is low from the address state through the last data state, which is 3·(2+w) clocks for w wait states, and returns high for the closing state.
- R4: When a request is accepted, the bus width is set as follows. If `cfg_dyn_width_i`=1, a `width_i` value of 1 gives a 16-bit cycle and 0 gives an 8-bit cycle. If `cfg_dyn_width_i`=0, every cycle is 8-bit whatever the value of `width_i`.
- R5: The lanes are encoded by the cycle address bit 0 (A0) and `bhe_n_o` on 16-bit cycles. A low-byte access uses A0=0 with `bhe_n_o`=1. A high-byte access uses A0=1 with `bhe_n_o`=0. A word uses A0=0 with `bhe_n_o`=0, and word requests ignore the request address bit 0. On 8-bit cycles `bhe_n_o` stays at 1.
- R6: On a read, `rd_n_o` is low for all data states, which is 3·(1+w) clocks, and `ad_oe_o` is 0. `ad_i` is captured on the last clock of the data states. The result appears on `rdata_o` when `done_o` is 1, as follows. A 16-bit word returns `ad_i`. A 16-bit byte returns the addressed lane, zero-extended. An 8-bit byte returns `ad_i[7:0]`, zero-extended.
- R7: In single-strobe mode (`cfg_split_wr_i`=0), every write drives `wr_n_o` low for 3·(1+w) clocks and keeps `wrh_n_o` at 1. During every write, `ad_oe_o` is 1 while the strobe is low. The data on `ad_o` is then one of the following. A 16-bit word drives the write data. A 16-bit byte drives the byte on both lanes. An 8-bit cycle drives the byte on `ad_o[7:0]` and address bits 15:8 on `ad_o[15:8]`.
- R8: In split-strobe mode (`cfg_split_wr_i`=1), `wr_n_o` is the low-lane strobe and `wrh_n_o` is the high-lane strobe. A lane's strobe goes low only when that lane is written. An even byte writes the low lane and an odd byte writes the high lane. A 16-bit word writes both lanes. A split strobe starts one clock after the first data state begins and stays low for 3·(1+w)−1 clocks.
- R9: `ready_i` is sampled on the last clock of each data state. A sample of 0 adds one more 3-clock data state, and a sample of 1 moves on to the closing state.
- R10: At most `cfg_max_wait_i` wait states are added, even if `ready_i` stays low.
- R11: `inst_o` is 1 from the address state through the closing state of a read with the fetch flag set, and 0 for all other accesses.
- R12: A word request on an 8-bit cycle runs as two byte cycles, one after the other. The first cycle uses A0=0 and carries the low byte. The second uses A0=1 and carries the high byte. The read result is {second byte, first byte}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request; held until `busy_o` rises |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_word_i | input | 1 | 1 = word, 0 = byte |
| req_fetch_i | input | 1 | Read is an instruction fetch |
| req_addr_i | input | 16 | Byte address |
| req_wdata_i | input | 16 | Write data (byte requests use bits 7:0) |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Read result, valid when `done_o` is 1 |
| cfg_dyn_width_i | input | 1 | Enables per-request width from `width_i` |
| cfg_adv_i | input | 1 | 1 = address-valid strobe, 0 = latch strobe |
| cfg_split_wr_i | input | 1 | 1 = per-lane write strobes |
| cfg_max_wait_i | input | 4 | Maximum wait states per cycle |
| clkout_o | output | 1 | Divided clock output, high on the first clock of each state |
| ad_o | output | 16 | Address/data bus out |
| ad_oe_o | output | 1 | Bus output enable |
| ad_i | input | 16 | Address/data bus in |
| ale_o | output | 1 | Address-latch / address-valid strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, or low-lane write strobe in split mode |
| wrh_n_o | output | 1 | High-lane write strobe in split mode |
| bhe_n_o | output | 1 | High-byte enable, active low |
| inst_o | output | 1 | Instruction-fetch flag |
| ready_i | input | 1 | Ready; low requests a wait state |
| width_i | input | 1 | Width pin; 1 = 16-bit |

## Verification
The hardest case to reach is a split write strobe that is being stretched by wait states up to the cap. The strobe starts one clock late, so `ready_i` has to be released exactly on a data-state boundary that the bench cannot see directly. The bench counts the strobe-low clocks of the current cycle and holds `ready_i` low until that count passes the boundary of the N-th data state. This count works for both strobe shapes. Holding `ready_i` low longer than the configured maximum then shows the cap. The same counter runs on the two halves of a split word, so each half gets the same number of waits.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    XB_IDLE = 2'd0,
    XB_ADDR = 2'd1,
    XB_DATA = 2'd2,
    XB_END  = 2'd3
  } xb_state_e;

  // Active-low high-byte enable for the current cycle.
  function automatic logic bhe_n_for(input logic is16, input logic word, input logic a0);
    return !(is16 && (word || a0));
  endfunction

  // Written or read lanes as {high, low}.
  function automatic logic [1:0] lanes_for(input logic is16, input logic word, input logic a0);
    if (is16 && word) return 2'b11;
    return a0 ? 2'b10 : 2'b01;
  endfunction

  // A request turns into two byte cycles when a word meets a narrow bus.
  function automatic logic needs_split(input logic is16, input logic word);
    return word && !is16;
  endfunction

endpackage

// File: rtl/xbus_phase.sv
module xbus_phase #(
  parameter int OSC_PER_STATE = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic first_ph_o,
  output logic last_ph_o
);
  localparam int PH_W = (OSC_PER_STATE > 1) ? $clog2(OSC_PER_STATE) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSC_PER_STATE - 1);

  logic [PH_W-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ph <= '0;
    else if (ph == PH_LAST)  ph <= '0;
    else                     ph <= ph + PH_W'(1);
  end

  assign first_ph_o = (ph == '0);
  assign last_ph_o  = (ph == PH_LAST);

  // R2: one clock high, then low until the next state
  a_r2_clkout_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    first_ph_o |=> !first_ph_o);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int DW     = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last_ph_i,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic              req_word_i,
  input  logic              req_fetch_i,
  input  logic [DW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic              width_i,
  input  logic              cfg_dyn_i,
  input  logic              ready_i,
  input  logic [WAIT_W-1:0] cfg_max_wait_i,
  output xb_state_e         state_o,
  output logic [WAIT_W-1:0] waits_o,
  output logic              we_o,
  output logic              word_o,
  output logic              fetch_o,
  output logic              is16_o,
  output logic              second_o,
  output logic [DW-1:0]     cur_addr_o,
  output logic [DW-1:0]     wdata_o,
  output logic              data_close_o,
  output logic              done_o
);
  xb_state_e         state;
  logic [WAIT_W-1:0] waits;
  logic              r_we, r_word, r_fetch, r_is16, r_second;
  logic [DW-1:0]     r_addr, r_wdata;

  // Named events for the checks below and for the lane logic.
  logic launch, wait_insert, data_close, more_bytes;
  assign launch      = last_ph_i && (state == XB_IDLE) && req_i;
  assign wait_insert = last_ph_i && (state == XB_DATA) && !ready_i && (waits != cfg_max_wait_i);
  assign data_close  = last_ph_i && (state == XB_DATA) && !wait_insert;
  assign more_bytes  = needs_split(r_is16, r_word) && !r_second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= XB_IDLE;
      waits    <= '0;
      r_we     <= 1'b0;
      r_word   <= 1'b0;
      r_fetch  <= 1'b0;
      r_is16   <= 1'b0;
      r_second <= 1'b0;
      r_addr   <= '0;
      r_wdata  <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (last_ph_i) begin
        unique case (state)
          XB_IDLE: if (launch) begin
            state    <= XB_ADDR;
            r_we     <= req_we_i;
            r_word   <= req_word_i;
            r_fetch  <= req_fetch_i;
            r_addr   <= req_addr_i;
            r_wdata  <= req_wdata_i;
            r_is16   <= cfg_dyn_i & width_i;
            r_second <= 1'b0;
          end
          XB_ADDR: begin
            state <= XB_DATA;
            waits <= '0;
          end
          XB_DATA: begin
            if (wait_insert) waits <= waits + WAIT_W'(1);
            else             state <= XB_END;
          end
          XB_END: begin
            if (more_bytes) begin
              state    <= XB_ADDR;
              r_second <= 1'b1;
            end else begin
              state  <= XB_IDLE;
              done_o <= 1'b1;
            end
          end
          default: state <= XB_IDLE;
        endcase
      end
    end
  end

  assign state_o      = state;
  assign waits_o      = waits;
  assign we_o         = r_we;
  assign word_o       = r_word;
  assign fetch_o      = r_fetch;
  assign is16_o       = r_is16;
  assign second_o     = r_second;
  assign wdata_o      = r_wdata;
  assign data_close_o = data_close;
  assign cur_addr_o   = r_word ? {r_addr[DW-1:1], r_second} : r_addr;

  // R9: a wait state is only added after a low ready sample
  a_r9_wait_needs_low_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XB_DATA && waits > $past(waits)) |-> !$past(ready_i));
  // R10: the wait count never passes the configured cap
  a_r10_wait_capped: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XB_DATA) |-> (waits <= cfg_max_wait_i));
  // R4: with per-request width disabled the cycle is narrow
  a_r4_narrow_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !cfg_dyn_i) |=> !r_is16);
endmodule

// File: rtl/xbus_lanes.sv
module xbus_lanes
  import xbus_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  xb_state_e           state_i,
  input  logic                is16_i,
  input  logic                word_i,
  input  logic                we_i,
  input  logic                second_i,
  input  logic [2*BYTE_W-1:0] cur_addr_i,
  input  logic [2*BYTE_W-1:0] wdata_i,
  input  logic [2*BYTE_W-1:0] ad_i,
  input  logic                data_close_i,
  output logic [2*BYTE_W-1:0] ad_o,
  output logic                ad_oe_o,
  output logic                bhe_n_o,
  output logic [1:0]          lanes_o,
  output logic [2*BYTE_W-1:0] rdata_o
);
  localparam int DW = 2 * BYTE_W;

  logic              a0;
  logic [BYTE_W-1:0] wr_byte, lo_in, hi_in;
  logic [DW-1:0]     data_word;

  assign a0      = cur_addr_i[0];
  assign lo_in   = ad_i[BYTE_W-1:0];
  assign hi_in   = ad_i[DW-1:BYTE_W];
  assign wr_byte = (word_i && second_i) ? wdata_i[DW-1:BYTE_W] : wdata_i[BYTE_W-1:0];

  always_comb begin
    if (is16_i) data_word = word_i ? wdata_i : {wr_byte, wr_byte};
    else        data_word = {cur_addr_i[DW-1:BYTE_W], wr_byte};
  end

  assign ad_o    = (state_i == XB_ADDR) ? cur_addr_i : data_word;
  assign ad_oe_o = (state_i == XB_ADDR) ||
                   (we_i && (state_i == XB_DATA || state_i == XB_END));
  assign bhe_n_o = bhe_n_for(is16_i, word_i, a0);
  assign lanes_o = lanes_for(is16_i, word_i, a0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
    end else if (data_close_i && !we_i) begin
      if (is16_i && word_i) rdata_o <= ad_i;
      else if (is16_i)      rdata_o <= {{BYTE_W{1'b0}}, (a0 ? hi_in : lo_in)};
      else if (second_i)    rdata_o[DW-1:BYTE_W] <= lo_in;
      else                  rdata_o <= {{BYTE_W{1'b0}}, lo_in};
    end
  end

  // R12: the second half of a split word addresses the odd byte
  a_r12_second_is_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == XB_ADDR && second_i) |-> cur_addr_i[0]);
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int BYTE_W        = 8,
  parameter int WAIT_W        = 4,
  parameter int OSC_PER_STATE = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic                req_we_i,
  input  logic                req_word_i,
  input  logic                req_fetch_i,
  input  logic [2*BYTE_W-1:0] req_addr_i,
  input  logic [2*BYTE_W-1:0] req_wdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [2*BYTE_W-1:0] rdata_o,
  input  logic                cfg_dyn_width_i,
  input  logic                cfg_adv_i,
  input  logic                cfg_split_wr_i,
  input  logic [WAIT_W-1:0]   cfg_max_wait_i,
  output logic                clkout_o,
  output logic [2*BYTE_W-1:0] ad_o,
  output logic                ad_oe_o,
  input  logic [2*BYTE_W-1:0] ad_i,
  output logic                ale_o,
  output logic                rd_n_o,
  output logic                wr_n_o,
  output logic                wrh_n_o,
  output logic                bhe_n_o,
  output logic                inst_o,
  input  logic                ready_i,
  input  logic                width_i
);
  localparam int DW = 2 * BYTE_W;

  logic              first_ph, last_ph;
  xb_state_e         state;
  logic [WAIT_W-1:0] waits;
  logic              we, word, fetch, is16, second, data_close, bhe_raw;
  logic [DW-1:0]     cur_addr, wdata;
  logic [1:0]        lanes;

  xbus_phase #(.OSC_PER_STATE(OSC_PER_STATE)) u_phase (
    .clk(clk), .rst_n(rst_n), .first_ph_o(first_ph), .last_ph_o(last_ph)
  );

  xbus_seq #(.DW(DW), .WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .last_ph_i(last_ph),
    .req_i(req_i), .req_we_i(req_we_i), .req_word_i(req_word_i),
    .req_fetch_i(req_fetch_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .width_i(width_i), .cfg_dyn_i(cfg_dyn_width_i), .ready_i(ready_i),
    .cfg_max_wait_i(cfg_max_wait_i),
    .state_o(state), .waits_o(waits), .we_o(we), .word_o(word), .fetch_o(fetch),
    .is16_o(is16), .second_o(second), .cur_addr_o(cur_addr), .wdata_o(wdata),
    .data_close_o(data_close), .done_o(done_o)
  );

  xbus_lanes #(.BYTE_W(BYTE_W)) u_lanes (
    .clk(clk), .rst_n(rst_n), .state_i(state), .is16_i(is16), .word_i(word),
    .we_i(we), .second_i(second), .cur_addr_i(cur_addr), .wdata_i(wdata),
    .ad_i(ad_i), .data_close_i(data_close),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .bhe_n_o(bhe_raw), .lanes_o(lanes),
    .rdata_o(rdata_o)
  );

  // Strobe generation from the sequencer state.
  logic in_cyc, addr_ph, data_ph, wr_act, split_on;
  assign in_cyc   = (state != XB_IDLE);
  assign addr_ph  = (state == XB_ADDR);
  assign data_ph  = (state == XB_DATA);
  assign wr_act   = data_ph && we;
  assign split_on = wr_act && !(first_ph && waits == '0);

  assign busy_o   = in_cyc;
  assign clkout_o = first_ph;
  assign ale_o    = cfg_adv_i ? !(addr_ph || data_ph) : addr_ph;
  assign rd_n_o   = !(data_ph && !we);
  assign wr_n_o   = cfg_split_wr_i ? !(split_on && lanes[0]) : !wr_act;
  assign wrh_n_o  = cfg_split_wr_i ? !(split_on && lanes[1]) : 1'b1;
  assign bhe_n_o  = in_cyc ? bhe_raw : 1'b1;
  assign inst_o   = in_cyc && fetch && !we;

  // R1: strobes quiet outside an access
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XB_IDLE) |-> (rd_n_o && wr_n_o && wrh_n_o && bhe_n_o && !inst_o && !ad_oe_o));
  // R3: the latch strobe only appears while the address is driven
  a_r3_latch_with_address: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_adv_i && ale_o) |-> ad_oe_o);
  // R6: never read and write at once
  a_r6_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && (!wr_n_o || !wrh_n_o)));
  // R7: data is driven whenever a write strobe is low
  a_r7_write_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n_o || !wrh_n_o) |-> ad_oe_o);
  // R8: a split strobe falls only after the data state has begun
  a_r8_split_starts_late: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_split_wr_i && ($fell(wr_n_o) || $fell(wrh_n_o))) |-> $past(state == XB_DATA));
  // R11: the fetch flag rises with the address state
  a_r11_inst_from_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inst_o) |-> (state == XB_ADDR));
endmodule

// File: tb/test_xbus_ctrl.sv
`timescale 1ns/1ps
module test_xbus_ctrl;
  localparam int BW = 8;
  localparam int DW = 16;
  localparam int WW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 0, req_we_i = 0, req_word_i = 0, req_fetch_i = 0;
  logic [DW-1:0] req_addr_i = '0, req_wdata_i = '0;
  logic busy_o, done_o, clkout_o, ad_oe_o, ale_o, rd_n_o, wr_n_o, wrh_n_o, bhe_n_o, inst_o;
  logic [DW-1:0] rdata_o, ad_o, ad_i;
  logic cfg_dyn = 1, cfg_adv = 0, cfg_split = 0;
  logic [WW-1:0] cfg_max = 4'd3;
  logic ready_i = 1'b1;
  logic width_i = 1'b1;

  xbus_ctrl #(.BYTE_W(BW), .WAIT_W(WW), .OSC_PER_STATE(3)) i_xbus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_we_i(req_we_i), .req_word_i(req_word_i),
    .req_fetch_i(req_fetch_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .cfg_dyn_width_i(cfg_dyn), .cfg_adv_i(cfg_adv), .cfg_split_wr_i(cfg_split),
    .cfg_max_wait_i(cfg_max), .clkout_o(clkout_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .ad_i(ad_i), .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .wrh_n_o(wrh_n_o),
    .bhe_n_o(bhe_n_o), .inst_o(inst_o), .ready_i(ready_i), .width_i(width_i)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // Memory model: the read value depends on the latched address.
  logic [DW-1:0] lat_addr = '0;
  assign ad_i = lat_addr ^ 16'h5A3C;
  function automatic logic [DW-1:0] mem(input logic [DW-1:0] a);
    return a ^ 16'h5A3C;
  endfunction

  typedef struct {
    logic [DW-1:0] addr;
    logic          bhe_n;
    logic [2:0]    mask;   // {read, low/common write, high write}
    int            len;
    logic          oe;
    logic [DW-1:0] wd;
    logic          inst;
    int            ale;
    string         len_tag;
    string         mask_tag;
  } exp_t;
  exp_t q[$];

  int rdy_low = 0;
  int cyc_seen = 0;

  // Monitor: one record per bus cycle, compared when the strobe ends.
  logic prev_ale = 1'b0;
  int scnt = 0, ale_cnt = 0;
  logic [2:0] m_mask = '0;
  logic [DW-1:0] m_wd = '0;
  logic m_oe = 0, m_bhe = 1, m_inst = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cfg_adv ? (!ale_o && prev_ale) : (ale_o && !prev_ale)) begin
        lat_addr = ad_o;
        ale_cnt = 0;
      end
      if (cfg_adv ? !ale_o : ale_o) ale_cnt++;
      if (!rd_n_o || !wr_n_o || !wrh_n_o) begin
        scnt++;
        m_mask |= {!rd_n_o, !wr_n_o, !wrh_n_o};
        if (scnt == 1) begin
          m_wd = ad_o; m_oe = ad_oe_o; m_bhe = bhe_n_o; m_inst = inst_o;
        end
      end else if (scnt > 0) begin
        if (q.size() == 0) begin
          check("R3", "unexpected bus cycle", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check("R3", "latched address", lat_addr, e.addr);
          check("R3", "strobe-active clocks", ale_cnt, e.ale);
          check("R5", "high-byte enable", m_bhe, e.bhe_n);
          check(e.mask_tag, "strobe set", m_mask, e.mask);
          check(e.len_tag, "strobe length", scnt, e.len);
          check(e.mask_tag, "bus drive", m_oe, e.oe);
          check("R11", "fetch flag", m_inst, e.inst);
          if (e.oe) check("R7", "write data on bus", m_wd, e.wd);
        end
        cyc_seen++;
        scnt = 0;
        m_mask = '0;
      end
      prev_ale = ale_o;
      ready_i <= (rdy_low == 0) || (scnt >= 3 * rdy_low + 2);
    end
  end

  task automatic idle_check(input string req);
    check(req, "rd_n idle", rd_n_o, 1);
    check(req, "wr_n idle", wr_n_o, 1);
    check(req, "wrh_n idle", wrh_n_o, 1);
    check(req, "bhe_n idle", bhe_n_o, 1);
    check(req, "inst idle", inst_o, 0);
    check(req, "ad_oe idle", ad_oe_o, 0);
    check(req, "busy idle", busy_o, 0);
    check(req, "ale idle", ale_o, cfg_adv);
  endtask

  task automatic xfer(input logic we, input logic word, input logic fetch,
                      input logic [DW-1:0] addr, input logic [DW-1:0] wdata,
                      input logic wpin, input int nlow);
    logic is16;
    int w, ncyc, base, t;
    logic [DW-1:0] exp_rd;
    string rd_tag;
    is16 = cfg_dyn & wpin;
    w = (nlow < int'(cfg_max)) ? nlow : int'(cfg_max);
    ncyc = (word && !is16) ? 2 : 1;
    exp_rd = '0;
    for (int k = 0; k < ncyc; k++) begin
      exp_t e;
      logic [DW-1:0] a;
      logic lo, hi;
      logic [BW-1:0] b;
      a = word ? {addr[DW-1:1], k[0]} : addr;
      lo = (is16 && word) || !a[0];
      hi = (is16 && word) || a[0];
      b = (word && k == 1) ? wdata[15:8] : wdata[7:0];
      e.addr = a;
      e.bhe_n = !(is16 && (word || a[0]));
      e.mask = !we ? 3'b100 : (cfg_split ? {1'b0, lo, hi} : 3'b010);
      e.len = (we && cfg_split) ? 3 * (1 + w) - 1 : 3 * (1 + w);
      e.oe = we;
      e.wd = is16 ? (word ? wdata : {b, b}) : {a[15:8], b};
      e.inst = fetch && !we;
      e.ale = cfg_adv ? 3 * (2 + w) : 3;
      e.len_tag = (nlow > int'(cfg_max)) ? "R10" : (nlow > 0) ? "R9" :
                  (!we ? "R6" : (cfg_split ? "R8" : "R7"));
      e.mask_tag = !we ? "R6" : (cfg_split ? "R8" : "R7");
      q.push_back(e);
      if (is16 && word)  exp_rd = mem(a);
      else if (is16)     exp_rd = {8'h00, (a[0] ? mem(a) >> 8 : mem(a) & 16'hFF)} & 16'h00FF;
      else if (k == 1)   exp_rd[15:8] = mem(a) & 16'hFF;
      else               exp_rd = {8'h00, 8'(mem(a))};
    end
    rd_tag = (ncyc == 2) ? "R12" : ((!cfg_dyn && wpin) ? "R4" : "R6");
    base = cyc_seen;
    @(negedge clk);
    req_we_i = we; req_word_i = word; req_fetch_i = fetch;
    req_addr_i = addr; req_wdata_i = wdata; width_i = wpin; rdy_low = nlow;
    req_i = 1;
    t = 0;
    do begin @(negedge clk); t++; end while (!busy_o && t < 100);
    req_i = 0;
    t = 0;
    while (!done_o && t < 2000) begin @(negedge clk); t++; end
    check("R6", "request completes", done_o, 1);
    check((ncyc == 2) ? "R12" : "R4", "bus cycles per request", cyc_seen - base, ncyc);
    if (!we) check(rd_tag, "read result", rdata_o, exp_rd);
    rdy_low = 0;
    @(negedge clk);
    idle_check("R1");
  endtask

  initial begin
    #(5.0 * 20000);
    check("R1", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    int hi;
    repeat (4) @(negedge clk);
    idle_check("R1");
    rst_n = 1;
    repeat (2) @(negedge clk);
    idle_check("R1");
    hi = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (clkout_o) hi++; end
    check("R2", "clkout high clocks in 30", hi, 10);

    // Latch mode, common strobe, wide cycles.
    xfer(0, 1, 1, 16'h1234, 16'h0, 1, 0);   // word fetch, 16-bit
    xfer(1, 1, 0, 16'h2000, 16'hBEEF, 1, 0); // word write
    xfer(0, 0, 0, 16'h3001, 16'h0, 1, 0);   // odd byte read, R5
    xfer(0, 0, 0, 16'h3002, 16'h0, 1, 0);   // even byte read
    xfer(1, 0, 0, 16'h3003, 16'h0077, 1, 0);// odd byte write
    // Narrow cycles chosen by the pin, R12.
    xfer(1, 1, 0, 16'h4000, 16'hA55A, 0, 0);
    xfer(0, 1, 1, 16'h4100, 16'h0, 0, 0);
    xfer(0, 0, 0, 16'h4103, 16'h0, 0, 0);
    // Per-request width disabled: pin high still gives narrow, R4.
    cfg_dyn = 0;
    xfer(0, 1, 0, 16'h5000, 16'h0, 1, 0);
    xfer(0, 0, 0, 16'h5001, 16'h0, 1, 0);
    cfg_dyn = 1;
    // Split strobes, R8.
    cfg_split = 1;
    xfer(1, 1, 0, 16'h6000, 16'h1357, 1, 0);
    xfer(1, 0, 0, 16'h6003, 16'h00C3, 1, 0);
    xfer(1, 0, 0, 16'h6004, 16'h003C, 1, 0);
    xfer(1, 0, 0, 16'h6005, 16'h0011, 0, 0);
    xfer(1, 1, 0, 16'h6100, 16'h2468, 0, 0);
    // Ready-driven waits, R9.
    cfg_split = 0;
    xfer(0, 1, 0, 16'h7000, 16'h0, 1, 2);
    cfg_split = 1;
    xfer(1, 1, 0, 16'h7100, 16'h9876, 1, 1);
    xfer(1, 1, 0, 16'h7200, 16'h5432, 0, 2);
    // Ready held low past the cap, R10.
    cfg_max = 4'd2;
    xfer(1, 0, 0, 16'h7301, 16'h00AB, 1, 9);
    cfg_split = 0;
    xfer(0, 1, 0, 16'h7400, 16'h0, 1, 9);
    cfg_max = 4'd0;
    xfer(0, 0, 0, 16'h7500, 16'h0, 1, 3);
    cfg_max = 4'd3;
    // Address-valid mode, R3.
    cfg_adv = 1;
    @(negedge clk);
    idle_check("R1");
    xfer(0, 1, 1, 16'h8000, 16'h0, 1, 1);
    xfer(1, 1, 0, 16'h8100, 16'hCAFE, 0, 0);
    xfer(0, 0, 0, 16'h8201, 16'h0, 1, 0);
    check("R3", "no leftover expected cycles", q.size(), 0);
    finish_run();
  end
endmodule